// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block takes in a card's reply to a reader command. The reply has no start marker, no stop marker and no length field. The analog front end slices the subcarrier into a digital level. The receiver counts how many times that level changes inside fixed bit windows. A window with a moderate number of transitions holds a subcarrier burst and decodes as a 1. A window with too few or too many transitions decodes as a 0. Because the reply carries no framing, the caller must say in advance how many bits to expect. An all-zero reply looks the same as no card at all.

The caller arms the receiver with the expected bit count. The receiver then asks the external keystream generator to step forward twice and captures the keystream word that results. When the reader frame ends, the caller strobes `cmd_end`. After a fixed lead-in, the receiver samples the bit windows back to back, timed by a slow tick enable. It builds the reply LSB first, XORs it with the captured keystream and pulses `done`. It also resets its response timer, ready for the next frame.

Top module: `sc_edge_rx`

## Requirements
- R1: While reset is held, `rx_data` is 0, `done` is 0 and `ks_step` is 0.
- R2: An `arm` pulse accepted while idle makes `ks_step` high for exactly two consecutive cycles, starting the cycle after `arm`. In the cycle after that, `ks_word` is captured as the keystream for the frame.
- R3: After a `cmd_end` pulse following an accepted arm, the first bit window opens 490 `tick_en` ticks later. Each window lasts 150 ticks, and the next window starts at once. Cycles without `tick_en` do not advance the timing.
- R4: Every change of `lvl_in` seen inside a window adds one to that window's count. The count starts from zero in each window. Level changes before the first window have no effect on the decoded bits.
- R5: A window count strictly between 20 and 60 (21 to 59) decodes as 1. Any other count decodes as 0.
- R6: The window count saturates at 255, so 300 transitions in one window decode as 0.
- R7: Bit k of the reply is taken from window k, for k from 0 up to `arm_bits`-1. The result is that bit vector XOR the captured keystream with all bits at or above `arm_bits` forced to zero. Bits of `rx_data` at or above `arm_bits` are zero.
- R8: `done` is high for exactly one cycle, the cycle after the edge that closes the last window. `rx_data` takes its new value on that same edge and keeps it until the next `done`.
- R9: A `cmd_end` pulse that does not follow an accepted arm is ignored. No `done` is produced and `rx_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timing tick enable (one clock per 1.5 MHz period) |
| lvl_in | input | 1 | Hysteresis-sliced receive level |
| arm | input | 1 | Start strobe; accepted only while idle |
| arm_bits | input | NB_W (5) | Expected bit count, 1 to MAX_BITS, sampled with `arm` |
| cmd_end | input | 1 | End of the reader frame; starts the response timer |
| ks_word | input | MAX_BITS (16) | Current keystream word from the external generator |
| ks_step | output | 1 | Request to advance the keystream by one position |
| rx_data | output | MAX_BITS (16) | Decrypted reply, LSB first |
| done | output | 1 | One-cycle pulse when the reply is complete |

## Verification
Each window is driven with a chosen number of transitions. The counts include 0, 20, 21, 42, 59, 60, 61 and 150, which sit on both sides of each decision boundary. A count of 300, driven with a halved tick rate, separates a saturating counter from one that wraps to a value in the 1-band. Two windows in a row, 42 transitions followed by 30, show whether the counter is cleared between windows. Transitions during the lead-in, together with a `cmd_end` sent without an arm, show that stray activity outside a frame changes nothing. The keystream generator is modelled as a position counter, so the check also covers that exactly two steps are taken before capture.

// File: rtl/sc_edge_rx_pkg.sv
package sc_edge_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADV  = 3'd1,
        ST_CAP  = 3'd2,
        ST_WAIT = 3'd3,
        ST_LEAD = 3'd4,
        ST_WIN  = 3'd5
    } rx_state_e;

endpackage

// File: rtl/sc_edge_rx_span.sv
// Tick-driven interval timer: counts enabled ticks up to lim and flags expiry.
module sc_edge_rx_span #(
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [TMR_W-1:0] lim,
    output logic             expire
);
    logic [TMR_W-1:0] cnt_d, cnt_q;
    logic             hit;

    always_comb begin
        hit    = (cnt_q == lim - TMR_W'(1));
        expire = !clr && tick_en && hit;
        cnt_d  = cnt_q;
        if (clr)          cnt_d = '0;
        else if (tick_en) cnt_d = hit ? '0 : cnt_q + TMR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sc_edge_rx_edgecnt.sv
// Transition counter with saturation; cnt_now includes this cycle's transition.
module sc_edge_rx_edgecnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_now
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             prev_d, prev_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             flip;

    always_comb begin
        flip    = lvl ^ prev_q;
        prev_d  = lvl;
        cnt_now = (flip && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;
        cnt_d   = clr ? '0 : cnt_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= prev_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx
    import sc_edge_rx_pkg::*;
#(
    parameter int MAX_BITS   = 16,
    parameter int LEAD_TICKS = 490,
    parameter int WIN_TICKS  = 150,
    parameter int CNT_W      = 8,
    parameter int ONE_LO     = 20,
    parameter int ONE_HI     = 60,
    parameter int ADV_STEPS  = 2,
    localparam int NB_W      = $clog2(MAX_BITS + 1),
    localparam int IDX_W     = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
    localparam int SPAN_MAX  = (LEAD_TICKS > WIN_TICKS) ? LEAD_TICKS : WIN_TICKS,
    localparam int TMR_W     = $clog2(SPAN_MAX + 1),
    localparam int ADV_W     = (ADV_STEPS > 1) ? $clog2(ADV_STEPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                lvl_in,
    input  logic                arm,
    input  logic [NB_W-1:0]     arm_bits,
    input  logic                cmd_end,
    input  logic [MAX_BITS-1:0] ks_word,
    output logic                ks_step,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                done
);
    typedef struct packed {
        rx_state_e           st;
        logic [ADV_W-1:0]    adv;
        logic [NB_W-1:0]     nbits;
        logic [IDX_W-1:0]    idx;
        logic [MAX_BITS-1:0] ks;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] data;
        logic                done;
        logic                step;
    } rx_regs_t;

    rx_regs_t cur_q, nxt_d;

    logic             tmr_clr, tmr_expire, in_span;
    logic [TMR_W-1:0] tmr_lim;
    logic             cnt_clr;
    logic [CNT_W-1:0] win_cnt;
    logic             win_bit;
    logic [MAX_BITS-1:0] fin_acc, len_mask;
    logic [NB_W-1:0]  nbits_held;

    assign in_span = (cur_q.st == ST_LEAD) || (cur_q.st == ST_WIN);
    assign tmr_clr = !in_span;
    assign tmr_lim = (cur_q.st == ST_LEAD) ? TMR_W'(LEAD_TICKS) : TMR_W'(WIN_TICKS);
    assign cnt_clr = (cur_q.st != ST_WIN) || tmr_expire;

    sc_edge_rx_span #(.TMR_W(TMR_W)) u_span (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick_en(tick_en),
        .lim(tmr_lim), .expire(tmr_expire)
    );

    sc_edge_rx_edgecnt #(.CNT_W(CNT_W)) u_edges (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_in), .clr(cnt_clr), .cnt_now(win_cnt)
    );

    always_comb begin
        win_bit = (win_cnt > CNT_W'(ONE_LO)) && (win_cnt < CNT_W'(ONE_HI));
        fin_acc = cur_q.acc;
        fin_acc[cur_q.idx] = win_bit;
        for (int i = 0; i < MAX_BITS; i++) len_mask[i] = (i < int'(cur_q.nbits));
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: if (arm) begin
                nxt_d.st    = ST_ADV;
                nxt_d.adv   = '0;
                nxt_d.nbits = arm_bits;
                nxt_d.idx   = '0;
                nxt_d.acc   = '0;
                nxt_d.step  = 1'b1;
            end
            ST_ADV: begin
                if (int'(cur_q.adv) == ADV_STEPS - 1) begin
                    nxt_d.st   = ST_CAP;
                    nxt_d.step = 1'b0;
                end else begin
                    nxt_d.adv  = cur_q.adv + ADV_W'(1);
                    nxt_d.step = 1'b1;
                end
            end
            ST_CAP: begin
                nxt_d.ks = ks_word;
                nxt_d.st = ST_WAIT;
            end
            ST_WAIT: if (cmd_end) nxt_d.st = ST_LEAD;
            ST_LEAD: if (tmr_expire) nxt_d.st = ST_WIN;
            ST_WIN: if (tmr_expire) begin
                nxt_d.acc = fin_acc;
                if (int'(cur_q.idx) + 1 >= int'(cur_q.nbits)) begin
                    nxt_d.data = (fin_acc ^ cur_q.ks) & len_mask;
                    nxt_d.done = 1'b1;
                    nxt_d.st   = ST_IDLE;
                end else begin
                    nxt_d.idx = cur_q.idx + IDX_W'(1);
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ks_step    = cur_q.step;
    assign rx_data    = cur_q.data;
    assign done       = cur_q.done;
    assign nbits_held = cur_q.nbits;
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk #(
    parameter int MAX_BITS = 16,
    parameter int NB_W     = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic                ks_step,
    input logic [MAX_BITS-1:0] rx_data,
    input logic [NB_W-1:0]     nbits_held
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    step_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_step) |=> ks_step);

    // R2
    step_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_step && $past(ks_step)) |=> !ks_step);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> done);

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_data >> nbits_held) == '0));

    // R2
    step_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ks_step);
endmodule

bind sc_edge_rx sc_edge_rx_chk #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .ks_step(ks_step),
    .rx_data(rx_data), .nbits_held(nbits_held)
);

// File: tb/sim_sc_edge_rx.sv
`timescale 1ns/1ps
module sim_sc_edge_rx;
    localparam int MB   = 16;
    localparam int NBW  = $clog2(MB + 1);
    localparam int LEAD = 490;
    localparam int WIN  = 150;

    logic clk = 1'b0;
    logic rst_n, tick_en, lvl_in, arm, cmd_end;
    logic [NBW-1:0] arm_bits;
    logic [MB-1:0]  ks_word, rx_data;
    logic ks_step, done;

    int total = 0, bad = 0;
    int pos = 0, done_seen = 0;
    int cnt_tab [16];

    always #2.5 clk = ~clk;

    sc_edge_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .lvl_in(lvl_in),
        .arm(arm), .arm_bits(arm_bits), .cmd_end(cmd_end), .ks_word(ks_word),
        .ks_step(ks_step), .rx_data(rx_data), .done(done)
    );

    function automatic logic [MB-1:0] ks_fn(input int p);
        return MB'((p * 40503) ^ 23100);
    endfunction

    // external keystream generator model: a position counter
    always @(negedge clk) begin
        if (ks_step) pos <= pos + 1;
        if (done) done_seen <= done_seen + 1;
    end
    assign ks_word = ks_fn(pos);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one tick slot of d cycles, tick_en on the last cycle
    task automatic run_frame(input string name, input int nb, input int d, input int lead_tog);
        int p0, c, t, b, n;
        logic [MB-1:0] bits, msk, expd;
        p0 = pos;
        arm = 1'b1; arm_bits = NBW'(nb);
        @(negedge clk); arm = 1'b0;
        repeat (5) @(negedge clk);
        // R2: two keystream steps
        check(pos - p0 == 2, {name, " R2 step count"}, pos - p0, 2);
        cmd_end = 1'b1;
        @(negedge clk); cmd_end = 1'b0;
        // R3 lead-in; R4 toggles here must not count
        for (t = 0; t < LEAD; t++) begin
            for (c = 0; c < d; c++) begin
                tick_en = (c == d - 1);
                if (c == 0 && t < lead_tog) lvl_in = ~lvl_in;
                @(negedge clk);
            end
        end
        bits = '0;
        for (b = 0; b < nb; b++) begin
            for (c = 0; c < WIN * d; c++) begin
                tick_en = ((c % d) == d - 1);
                if (c < cnt_tab[b]) lvl_in = ~lvl_in;
                @(negedge clk);
            end
            n = (cnt_tab[b] > 255) ? 255 : cnt_tab[b];
            bits[b] = (n > 20 && n < 60);
        end
        tick_en = 1'b0;
        msk = '0;
        for (int i = 0; i < nb; i++) msk[i] = 1'b1;
        expd = (bits ^ ks_fn(p0 + 2)) & msk;
        // R8 done in the cycle after the last window closes
        check(done == 1'b1, {name, " R8 done timing"}, int'(done), 1);
        // R5 R7 decoded data
        check(rx_data == expd, {name, " R5/R7 data"}, int'(rx_data), int'(expd));
        @(negedge clk);
        check(done == 1'b0, {name, " R8 done single"}, int'(done), 0);
        repeat (3) @(negedge clk);
        check(rx_data == expd, {name, " R8 data held"}, int'(rx_data), int'(expd));
    endtask

    task automatic t_reset;
        check(rx_data == '0, "R1 data", int'(rx_data), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(ks_step == 1'b0, "R1 step", int'(ks_step), 0);
    endtask

    task automatic t_basic;
        cnt_tab = '{42, 0, 21, 59, 20, 60, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        run_frame("basic R3", 6, 1, 0);
    endtask

    task automatic t_clear;
        // R4: 42 then 30 needs clearing; lead-in toggles must be ignored
        cnt_tab = '{42, 30, 0, 45, 10, 25, 58, 61, 42, 42, 0, 22, 0, 0, 0, 0};
        run_frame("clear R4", 12, 1, 50);
    endtask

    task automatic t_slow;
        // R6: 300 transitions saturate to 255; R3 half tick rate
        cnt_tab = '{300, 42, 150, 21, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        run_frame("slow R6 R3", 4, 2, 0);
    endtask

    task automatic t_full;
        cnt_tab = '{21, 59, 42, 0, 42, 19, 40, 60, 33, 1, 50, 42, 100, 24, 57, 42};
        run_frame("full R7", 16, 1, 0);
    endtask

    task automatic t_ignore;
        int d0;
        logic [MB-1:0] keep;
        d0 = done_seen; keep = rx_data;
        // R9: cmd_end without arm
        cmd_end = 1'b1;
        @(negedge clk); cmd_end = 1'b0;
        for (int c = 0; c < LEAD + 3 * WIN; c++) begin
            tick_en = 1'b1;
            if (c % 3 == 0) lvl_in = ~lvl_in;
            @(negedge clk);
        end
        tick_en = 1'b0;
        repeat (4) @(negedge clk);
        check(done_seen == d0, "R9 no done", done_seen - d0, 0);
        check(rx_data == keep, "R9 data kept", int'(rx_data), int'(keep));
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; lvl_in = 1'b0; arm = 1'b0;
        cmd_end = 1'b0; arm_bits = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_clear();
        t_slow();
        t_full();
        t_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule